// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low select line and a data clock made from the system clock by a fixed divider, and samples the serial data line. A one-cycle `start` pulse begins a conversion. The controller drops the sampling clocks and the null bit that come before the data, checks that the null bit was low, and assembles the MSB-first word.

Three read kinds are supported. A full read takes all data bits. A short read stops after the first N bits by raising select early. The result is left-aligned, its unread low bits are zero, and a count output reports how many bits are valid. A verify read keeps clocking after the last bit and compares the LSB-first replay with the word already captured. Each transfer ends with a one-cycle `result_valid` strobe. Select then stays high for a programmed gap before the next conversion may start.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, and `busy` and `result_valid` are 0.
- R2: A `start` pulse taken while `busy` is low drives `cs_n` low and `busy` high on the next clock. A `start` seen while `busy` is high is ignored: the running transfer is unchanged and no further transfer follows.
- R3: `sclk` is low whenever `cs_n` is high. Each `sclk` level lasts exactly HALF_DIV system clocks, and the first rising edge comes HALF_DIV clocks after `cs_n` falls.
- R4: `sdata` is sampled at the third rising `sclk` edge as the null bit. If it is 1, `null_err` is 1 when the result is delivered.
- R5: On a full read, rising edges 4 to 15 capture result bits 11 down to 0. Select is released after exactly 15 rising edges.
- R6: `read_len` values 1 to 11 give a short read of N bits: exactly 3+N rising edges are made. `result` holds the bits in its top N positions with zeros below, and `bit_count` equals N. For full and verify reads `bit_count` is 12.
- R7: With `verify_en` set on a full read, 26 rising edges are made. Edges 16 to 26 are compared with result bits 1 to 11, and any difference sets `mismatch`. `result` still holds the MSB-first word.
- R8: `result_valid` is a single-cycle pulse. It is raised in the same clock that `cs_n` returns high, and `null_err` and `mismatch` are valid alongside it. `busy` then stays high for CS_GAP clocks, so a `start` held high gives a select-high time of exactly CS_GAP+1 clocks.
- R9: A `read_len` of 0 or of 12 and above selects a full read. `verify_en` has no effect on a short read: the edge count stays 3+N and `mismatch` stays 0.
- R10: The parameters are checked at elaboration. The data clock must lie between 10 kHz and 1.2 MHz, each level must last at least 400 ns, and the select gap must be at least one data-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request pulse |
| read_len | input | 4 | Bits to read (1..11 short, else full) |
| verify_en | input | 1 | Clock the replay and compare it (full reads) |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select / conversion start |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Transfer or select gap in progress |
| result_valid | output | 1 | One-cycle strobe for result and flags |
| result | output | 12 | Captured word, left-aligned |
| bit_count | output | 4 | Number of valid bits in `result` |
| null_err | output | 1 | Null bit was read as 1 |
| mismatch | output | 1 | Replay did not match the word |

## Verification
The bench drives a behavioural converter that launches bits on falling `sclk`. It counts the rising edges seen while select is low. An off-by-one in the lead-in handling would shift every captured bit by one position or misread the null bit. A wrong stop count on short reads shows up as an edge total other than 3+N, or as stale low bits below the left-aligned word. The verify tests corrupt one replay bit, and an unindexed or reversed comparison would either miss it or flag clean data. Starts issued during a transfer and during the select gap check that a controller which re-arms too early would cut the gap or launch a stray conversion.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int unsigned SYS_CLK_HZ = 50_000_000,
  parameter int unsigned HALF_DIV   = 25,
  parameter int unsigned CS_GAP     = 50,
  parameter int unsigned DATA_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [$clog2(DATA_W+1)-1:0]   read_len,
  input  logic                          verify_en,
  input  logic                          sdata,
  output logic                          cs_n,
  output logic                          sclk,
  output logic                          busy,
  output logic                          result_valid,
  output logic [DATA_W-1:0]             result,
  output logic [$clog2(DATA_W+1)-1:0]   bit_count,
  output logic                          null_err,
  output logic                          mismatch
);

  localparam int LEN_W  = $clog2(DATA_W+1);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int DIV_W  = $clog2(HALF_DIV+1);
  localparam int GAP_W  = $clog2(CS_GAP+1);
  localparam int RISE_W = $clog2(2*DATA_W+4);
  localparam logic [RISE_W-1:0] R_NULL = RISE_W'(3);
  localparam logic [RISE_W-1:0] R_FULL = RISE_W'(3 + DATA_W);
  localparam logic [RISE_W-1:0] R_VER  = RISE_W'(2 + 2*DATA_W);
  localparam longint HALF_NS = longint'(HALF_DIV) * 64'd1_000_000_000 / longint'(SYS_CLK_HZ);
  localparam longint DCLK_HZ = longint'(SYS_CLK_HZ) / (2 * longint'(HALF_DIV));
  localparam bit CFG_OK = (HALF_DIV >= 1) && (DATA_W >= 2) && (HALF_NS >= 400) &&
                          (DCLK_HZ >= 10_000) && (DCLK_HZ <= 1_200_000) &&
                          (CS_GAP >= 2*HALF_DIV);

  // R10: reject divider and gap settings outside the converter's clock limits
  generate
    if (!CFG_OK) begin : g_cfg_bad
      $error("adc_serial_reader: data clock or select gap out of range");
    end
  endgenerate

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} state_t;

  state_t              st;
  logic [DIV_W-1:0]    div;
  logic [GAP_W-1:0]    gap;
  logic [RISE_W-1:0]   rises, last;
  logic                ver_q;
  logic [LEN_W-1:0]    len_q;

  wire                 tick      = (div == DIV_W'(HALF_DIV-1));
  wire                 short_req = (read_len != '0) && (read_len < LEN_W'(DATA_W));
  wire [RISE_W-1:0]    rise_nx   = rises + 1'b1;
  wire [RISE_W-1:0]    cap_pos   = R_FULL - rise_nx;
  wire [RISE_W-1:0]    rep_pos   = rise_nx - R_FULL;
  wire [IDX_W-1:0]     cap_idx   = cap_pos[IDX_W-1:0];
  wire [IDX_W-1:0]     rep_idx   = rep_pos[IDX_W-1:0];

  assign busy      = (st != S_IDLE);
  assign bit_count = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cs_n         <= 1'b1;
      sclk         <= 1'b0;
      div          <= '0;
      gap          <= '0;
      rises        <= '0;
      last         <= '0;
      ver_q        <= 1'b0;
      len_q        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      null_err     <= 1'b0;
      mismatch     <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st       <= S_RUN;
            cs_n     <= 1'b0;
            div      <= '0;
            rises    <= '0;
            result   <= '0;
            null_err <= 1'b0;
            mismatch <= 1'b0;
            ver_q    <= verify_en && !short_req;
            len_q    <= short_req ? read_len : LEN_W'(DATA_W);
            if (short_req)      last <= R_NULL + RISE_W'(read_len);
            else if (verify_en) last <= R_VER;
            else                last <= R_FULL;
          end
        end
        S_RUN: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick && !sclk) begin
            sclk  <= 1'b1;
            rises <= rise_nx;
            if (rise_nx == R_NULL)
              null_err <= sdata;
            else if (rise_nx > R_NULL && rise_nx <= R_FULL)
              result[cap_idx] <= sdata;
            else if (rise_nx > R_FULL && ver_q && (sdata != result[rep_idx]))
              mismatch <= 1'b1;
          end else if (tick && sclk) begin
            sclk <= 1'b0;
            if (rises == last) begin
              cs_n         <= 1'b1;
              st           <= S_GAP;
              gap          <= '0;
              result_valid <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gap == GAP_W'(CS_GAP-1)) st <= S_IDLE;
          else gap <= gap + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Level-length monitor for the data clock
  logic             sclk_q;
  logic [DIV_W-1:0] hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      hold   <= DIV_W'(HALF_DIV);
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q)              hold <= DIV_W'(1);
      else if (hold != DIV_W'(HALF_DIV)) hold <= hold + 1'b1;
    end
  end

  p_sclk_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_q) |-> (hold >= DIV_W'(HALF_DIV)));
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_cs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start && !busy));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_valid_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && busy));
  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (bit_count >= LEN_W'(1) && bit_count <= LEN_W'(DATA_W)));
  p_left_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (DATA_W'(result << bit_count) == '0));
  p_short_no_verify_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && bit_count != LEN_W'(DATA_W)) |-> !mismatch);

endmodule

// File: tb/adc_serial_reader_tb_top.sv
`timescale 1ns/1ps
module adc_serial_reader_tb_top;
  localparam int HALF_DIV = 25;
  localparam int CS_GAP   = 50;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_en = 1'b0, sdata = 1'b0;
  logic [3:0] read_len = 4'd0;
  logic cs_n, sclk, busy, result_valid, null_err, mismatch;
  logic [11:0] result;
  logic [3:0] bit_count;

  int total = 0, bad = 0;
  logic [11:0] adc_word = 12'h000;
  logic null_val = 1'b0;
  int flip_f = -1;
  int falls = 0, rises = 0;
  realtime t_cs_fall = 0, t_r1 = 0, t_r2 = 0;

  always #10 clk = ~clk;

  adc_serial_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .read_len(read_len),
    .verify_en(verify_en), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .result_valid(result_valid), .result(result),
    .bit_count(bit_count), .null_err(null_err), .mismatch(mismatch));

  function automatic logic model_bit(int f);
    logic b;
    if (f == 2) return null_val;
    if (f >= 3 && f <= 14) return adc_word[14-f];
    if (f >= 15 && f <= 25) begin
      b = adc_word[f-14];
      if (f == flip_f) b = ~b;
      return b;
    end
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin
    falls = 0; rises = 0; sdata = 1'b0; t_cs_fall = $realtime;
  end
  always @(negedge sclk) if (!cs_n) begin
    falls++; sdata = model_bit(falls);
  end
  always @(posedge sclk) if (!cs_n) begin
    rises++;
    if (rises == 1) t_r1 = $realtime;
    if (rises == 2) t_r2 = $realtime;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid(string tag);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (result_valid) return;
    end
    check({tag, " valid timeout"}, 0, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check("idle timeout", 0, 1);
  endtask

  task automatic launch(logic [3:0] len, logic ver);
    @(negedge clk);
    read_len = len; verify_en = ver; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 cs_n low after start", cs_n, 0);
    check("R2 busy after start", busy, 1);
  endtask

  task automatic t_reset();
    check("R1 cs_n", cs_n, 1);
    check("R1 sclk", sclk, 0);
    check("R1 busy", busy, 0);
    check("R1 valid", result_valid, 0);
  endtask

  task automatic t_full(logic [11:0] w);
    adc_word = w; null_val = 0; flip_f = -1;
    launch(4'd0, 1'b0);
    wait_valid("R5");
    check("R5 result", result, w);
    check("R5 rises", rises, 15);
    check("R6 bit_count full", bit_count, 12);
    check("R4 null ok", null_err, 0);
    check("R8 cs_n high at valid", cs_n, 1);
    @(negedge clk);
    check("R8 valid one cycle", result_valid, 0);
    wait_idle();
  endtask

  task automatic t_timing();
    adc_word = 12'h5A5; null_val = 0; flip_f = -1;
    launch(4'd0, 1'b0);
    wait_valid("R3");
    check("R3 first rise delay ns", int'(t_r1 - t_cs_fall), HALF_DIV*20);
    check("R3 sclk period ns", int'(t_r2 - t_r1), 2*HALF_DIV*20);
    // R10: 1000 ns period is within 10 kHz..1.2 MHz, level >= 400 ns
    check("R10 clock within limits", ((t_r2 - t_r1) >= 833.0) && ((t_r2 - t_r1) <= 100000.0), 1);
    check("R3 sclk low after release", sclk, 0);
    wait_idle();
  endtask

  task automatic t_short(logic [11:0] w, int n, logic ver, int flip);
    logic [11:0] exp;
    adc_word = w; null_val = 0; flip_f = flip;
    exp = w & ~(12'hFFF >> n);
    launch(4'(n), ver);
    wait_valid("R6");
    check("R6 short result", result, exp);
    check("R6 short rises", rises, 3+n);
    check("R6 short bit_count", bit_count, n);
    if (ver) check("R9 verify ignored on short", mismatch, 0);
    wait_idle();
  endtask

  task automatic t_verify(logic [11:0] w, int flip, logic exp_mm);
    adc_word = w; null_val = 0; flip_f = flip;
    launch(4'd0, 1'b1);
    wait_valid("R7");
    check("R7 verify result", result, w);
    check("R7 verify rises", rises, 26);
    check("R7 mismatch flag", mismatch, exp_mm);
    wait_idle();
    flip_f = -1;
  endtask

  task automatic t_null();
    adc_word = 12'h123; null_val = 1; flip_f = -1;
    launch(4'd0, 1'b0);
    wait_valid("R4");
    check("R4 null_err set", null_err, 1);
    check("R4 data still captured", result, 12'h123);
    wait_idle();
    null_val = 0;
  endtask

  task automatic t_len_full(logic [3:0] len);
    adc_word = 12'h9C3; null_val = 0; flip_f = -1;
    launch(len, 1'b0);
    wait_valid("R9");
    check("R9 len selects full rises", rises, 15);
    check("R9 len selects full result", result, 12'h9C3);
    check("R9 len selects full count", bit_count, 12);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    int valids;
    adc_word = 12'h3C6; null_val = 0; flip_f = -1;
    launch(4'd0, 1'b0);
    repeat (300) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_valid("R2");
    check("R2 run unchanged rises", rises, 15);
    check("R2 run unchanged result", result, 12'h3C6);
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    valids = 0;
    for (int i = 0; i < CS_GAP + 200; i++) begin
      @(negedge clk);
      if (result_valid || !cs_n) valids++;
    end
    check("R2 no stray transfer", valids, 0);
    check("R2 idle after gap", busy, 0);
  endtask

  task automatic t_gap();
    int hi;
    adc_word = 12'h0F0; null_val = 0; flip_f = -1;
    launch(4'd0, 1'b0);
    wait_valid("R8");
    read_len = 4'd0; verify_en = 1'b0; start = 1'b1;
    hi = 0;
    for (int i = 0; i < CS_GAP + 20; i++) begin
      if (!cs_n) break;
      hi++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R8 select gap cycles", hi, CS_GAP + 1);
    wait_valid("R8 second");
    check("R8 second result", result, 12'h0F0);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_full(12'hA5C);
    t_full(12'h000);
    t_full(12'hFFF);
    t_timing();
    t_short(12'hB3D, 4, 1'b0, -1);
    t_short(12'hFFF, 11, 1'b0, -1);
    t_short(12'h801, 1, 1'b0, -1);
    t_short(12'h6E1, 5, 1'b1, 17);
    t_verify(12'h6E1, -1, 1'b0);
    t_verify(12'h6E1, 20, 1'b1);
    t_verify(12'h001, 25, 1'b1);
    t_null();
    t_len_full(4'd12);
    t_len_full(4'd15);
    t_busy_ignore();
    t_gap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule